// File: doc/BRIEF.md
# Spindle Start/Stop Sequencer

This block is the clocked controller that brings a removable-cartridge disk drive from rest to a ready state and back. A run request, taken from either the operator switch or the host line, starts the spindle once a cartridge is present. The sequencer then waits for speed to come within tolerance, runs a timed purge, loads the heads and waits for the positioner to reach position mode. When ready, it raises its ready and lamp outputs. Dropping the request unloads the heads, brakes the spindle and returns to rest once rotation has stopped.

One delay counter serves every timed step. It is loaded with a separate parameter count on entry to each timed state, and it decrements on a clock-enable tick from a prescaler. The fault inputs, together with the spin-up and head-load watchdogs, force an emergency unload. That path skips the normal write/erase hold. It drives the emergency relay enable until the heads report retracted, and then joins the braking path. Servo, motor regulation and relay drivers lie outside this block and appear only as flags.

Top module: `spindle_seq`

## Requirements
- R1: A start is requested when either `op_run` or `host_run` is high. An accepted start (leaving rest) produces `start_pulse` high for exactly one clock.
- R2: While `cart_in` is low, no start is accepted: the block stays at rest, `safe_lamp` stays high and `start_pulse` stays low.
- R3: During spin-up, the purge begins only after `speed_ok` is high. If `SPINUP_TICKS` ticks pass without it, an emergency unload is raised.
- R4: The purge lasts `PURGE_TICKS` ticks with `purge_o` high, then the heads are loaded (`load_heads` high). `load_or_purge_n` is low exactly when either of those two levels is high.
- R5: While loading, `pos_mode` high moves the block to ready. If `LOAD_TICKS` ticks pass without it, an emergency unload is raised.
- R6: Any of `ext_emerg`, `xducer_fail`, `write_emerg`, `range_err`, `seek_time_err` or `power_clear`, while the spindle sequence is active, raises an emergency unload. The emergency unload drops `load_heads`, sets `emerg_flag` and holds `relay_en` until `heads_retracted`. `emerg_flag` stays set until the block is back at rest.
- R7: `disk_speed_err` is ignored before ready is reached. Once the block is ready, it raises an emergency unload.
- R8: In a normal unload, `load_heads` stays high while `wr_er_active` is high, and drops once it is low.
- R9: `brake_en` rises only after `heads_retracted` is high. Braking ends, and the block returns to rest, once rotation is no longer sensed.
- R10: Rotation is sensed when a `rot_pulse` has been seen within the last `ROT_WIN_TICKS` ticks. `cart_lock` is high while rotation is sensed or the block is not at rest, and `safe_lamp` is its inverse.
- R11: `run_lamp` is high from an accepted start until the request is dropped or a fault occurs. `ready_lamp` and `ready_o` are high in the ready state.
- R12: `sel_ready` equals ready AND `unit_sel`. `dly_ready` rises `DRDY_TICKS` ticks after ready is entered and is low on the first ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_run | input | 1 | Operator run switch level |
| host_run | input | 1 | Host start/stop line level |
| cart_in | input | 1 | Cartridge inserted switch |
| speed_ok | input | 1 | Spindle speed within tolerance |
| pos_mode | input | 1 | Positioner has reached position mode |
| wr_er_active | input | 1 | Write or erase in progress |
| heads_retracted | input | 1 | Heads are fully retracted |
| rot_pulse | input | 1 | Rotation detector pulse |
| unit_sel | input | 1 | Unit is selected |
| ext_emerg | input | 1 | External emergency unload command |
| xducer_fail | input | 1 | Position transducer failure |
| write_emerg | input | 1 | Write emergency condition |
| range_err | input | 1 | Positioner beyond legal travel |
| seek_time_err | input | 1 | Seek time exceeded |
| disk_speed_err | input | 1 | Disk speed error |
| power_clear | input | 1 | Unacceptable power condition |
| start_pulse | output | 1 | One-clock start-motor pulse |
| purge_o | output | 1 | Purge cycle level |
| load_heads | output | 1 | Load heads level |
| emerg_flag | output | 1 | Emergency unload started or present |
| brake_en | output | 1 | Brake current enable |
| cart_lock | output | 1 | Cartridge lock solenoid |
| relay_en | output | 1 | Emergency unload relay enable |
| load_or_purge_n | output | 1 | Low when purging or heads loaded |
| safe_lamp | output | 1 | Cartridge may be removed |
| run_lamp | output | 1 | Start in progress or running |
| ready_lamp | output | 1 | Ready lamp drive |
| ready_o | output | 1 | Ready flag |
| sel_ready | output | 1 | Ready and selected |
| dly_ready | output | 1 | Ready after the ready delay |

## Verification
On every cycle, the embedded properties check the following. The start pulse never lasts two clocks. A missing cartridge blocks a start. Braking begins only after retraction was reported. The heads stay loaded while a write is active unless an emergency intervenes. The relay enable implies the emergency flag. A rotation pulse always leaves the lock engaged. Delayed ready is low on entry to ready. The timed paths can only be shown by the bench's scenarios: the sequence order, both watchdog timeouts, each fault source, the disk speed error counting only after ready, and the return to rest once rotation stops.

// File: rtl/spindle_seq.sv
module spindle_seq #(
  parameter int PRESCALE      = 1000,
  parameter int SPINUP_TICKS  = 300,
  parameter int PURGE_TICKS   = 120,
  parameter int LOAD_TICKS    = 40,
  parameter int DRDY_TICKS    = 16,
  parameter int ROT_WIN_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_run,
  input  logic host_run,
  input  logic cart_in,
  input  logic speed_ok,
  input  logic pos_mode,
  input  logic wr_er_active,
  input  logic heads_retracted,
  input  logic rot_pulse,
  input  logic unit_sel,
  input  logic ext_emerg,
  input  logic xducer_fail,
  input  logic write_emerg,
  input  logic range_err,
  input  logic seek_time_err,
  input  logic disk_speed_err,
  input  logic power_clear,
  output logic start_pulse,
  output logic purge_o,
  output logic load_heads,
  output logic emerg_flag,
  output logic brake_en,
  output logic cart_lock,
  output logic relay_en,
  output logic load_or_purge_n,
  output logic safe_lamp,
  output logic run_lamp,
  output logic ready_lamp,
  output logic ready_o,
  output logic sel_ready,
  output logic dly_ready
);
  localparam int M1   = (SPINUP_TICKS > PURGE_TICKS) ? SPINUP_TICKS : PURGE_TICKS;
  localparam int M2   = (LOAD_TICKS > DRDY_TICKS) ? LOAD_TICKS : DRDY_TICKS;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int PW   = $clog2(PRESCALE + 1);
  localparam int RW   = $clog2(ROT_WIN_TICKS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SPIN, S_PURGE, S_LOAD, S_READY, S_UNLOAD, S_BRAKE, S_EMERG
  } st_t;

  st_t st, nx;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] dly_q, dly_ld;
  logic [RW-1:0] rot_q;
  logic tick, expired, rotating, req, active, fault;

  assign tick     = (pre_q == PW'(PRESCALE - 1));
  assign expired  = (dly_q == '0);
  assign rotating = (rot_q != RW'(ROT_WIN_TICKS));
  assign req      = op_run | host_run;
  assign active   = st inside {S_SPIN, S_PURGE, S_LOAD, S_READY, S_UNLOAD};
  assign fault    = ext_emerg | xducer_fail | write_emerg | range_err | seek_time_err |
                    power_clear | (st == S_READY && disk_speed_err);

  always_comb begin
    nx = st;
    if (active && fault) nx = S_EMERG;
    else case (st)
      S_IDLE:   if (req && cart_in) nx = S_SPIN;
      S_SPIN:   if (!req) nx = S_UNLOAD;
                else if (speed_ok) nx = S_PURGE;
                else if (expired) nx = S_EMERG;
      S_PURGE:  if (!req) nx = S_UNLOAD;
                else if (!speed_ok) nx = S_EMERG;
                else if (expired) nx = S_LOAD;
      S_LOAD:   if (!req) nx = S_UNLOAD;
                else if (pos_mode) nx = S_READY;
                else if (expired) nx = S_EMERG;
      S_READY:  if (!req) nx = S_UNLOAD;
      S_UNLOAD: if (!wr_er_active && heads_retracted) nx = S_BRAKE;
      S_BRAKE:  if (!rotating) nx = S_IDLE;
      S_EMERG:  if (heads_retracted) nx = S_BRAKE;
      default:  nx = S_IDLE;
    endcase
  end

  always_comb begin
    case (nx)
      S_SPIN:  dly_ld = CW'(SPINUP_TICKS);
      S_PURGE: dly_ld = CW'(PURGE_TICKS);
      S_LOAD:  dly_ld = CW'(LOAD_TICKS);
      S_READY: dly_ld = CW'(DRDY_TICKS);
      default: dly_ld = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pre_q       <= '0;
      dly_q       <= '0;
      rot_q       <= RW'(ROT_WIN_TICKS);
      start_pulse <= 1'b0;
      emerg_flag  <= 1'b0;
    end else begin
      st          <= nx;
      pre_q       <= tick ? '0 : pre_q + 1'b1;
      start_pulse <= (st == S_IDLE) && (nx == S_SPIN);
      if (nx != st) dly_q <= dly_ld;
      else if (tick && !expired) dly_q <= dly_q - 1'b1;
      if (rot_pulse) rot_q <= '0;
      else if (tick && rotating) rot_q <= rot_q + 1'b1;
      if (nx == S_EMERG) emerg_flag <= 1'b1;
      else if (nx == S_IDLE) emerg_flag <= 1'b0;
    end
  end

  assign purge_o         = (st == S_PURGE);
  assign load_heads      = (st == S_LOAD) || (st == S_READY) || (st == S_UNLOAD && wr_er_active);
  assign load_or_purge_n = ~(purge_o | load_heads);
  assign brake_en        = (st == S_BRAKE);
  assign relay_en        = (st == S_EMERG);
  assign cart_lock       = rotating || (st != S_IDLE);
  assign safe_lamp       = ~cart_lock;
  assign run_lamp        = st inside {S_SPIN, S_PURGE, S_LOAD, S_READY};
  assign ready_o         = (st == S_READY);
  assign ready_lamp      = ready_o;
  assign sel_ready       = ready_o & unit_sel;
  assign dly_ready       = ready_o & expired;

  p_start_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  p_no_cart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cart_in |=> !start_pulse);
  p_relay_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    relay_en |-> emerg_flag);
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_heads && wr_er_active) |=> (load_heads || emerg_flag || !wr_er_active));
  p_brake_retract_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake_en) |-> $past(heads_retracted));
  p_rot_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rot_pulse |=> cart_lock);
  p_dly_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> !dly_ready);
endmodule

// File: tb/test_spindle_seq.sv
module test_spindle_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_run = 0, host_run = 0, cart_in = 0, speed_ok = 0, pos_mode = 0;
  logic wr_er_active = 0, heads_retracted = 1, rot_pulse = 0, unit_sel = 0;
  logic [5:0] flt = '0;
  logic disk_speed_err = 0, spin = 0;
  logic start_pulse, purge_o, load_heads, emerg_flag, brake_en, cart_lock, relay_en;
  logic load_or_purge_n, safe_lamp, run_lamp, ready_lamp, ready_o, sel_ready, dly_ready;
  int checks = 0, failures = 0, pcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spindle_seq #(.PRESCALE(2), .SPINUP_TICKS(8), .PURGE_TICKS(4), .LOAD_TICKS(6),
                .DRDY_TICKS(3), .ROT_WIN_TICKS(4)) i_spindle_seq (
    .clk(clk), .rst_n(rst_n), .op_run(op_run), .host_run(host_run), .cart_in(cart_in),
    .speed_ok(speed_ok), .pos_mode(pos_mode), .wr_er_active(wr_er_active),
    .heads_retracted(heads_retracted), .rot_pulse(rot_pulse), .unit_sel(unit_sel),
    .ext_emerg(flt[0]), .xducer_fail(flt[1]), .write_emerg(flt[2]), .range_err(flt[3]),
    .seek_time_err(flt[4]), .disk_speed_err(disk_speed_err), .power_clear(flt[5]),
    .start_pulse(start_pulse), .purge_o(purge_o), .load_heads(load_heads),
    .emerg_flag(emerg_flag), .brake_en(brake_en), .cart_lock(cart_lock), .relay_en(relay_en),
    .load_or_purge_n(load_or_purge_n), .safe_lamp(safe_lamp), .run_lamp(run_lamp),
    .ready_lamp(ready_lamp), .ready_o(ready_o), .sel_ready(sel_ready), .dly_ready(dly_ready));

  initial forever begin
    @(negedge clk);
    rot_pulse <= spin & ~rot_pulse;
    if (start_pulse) pcnt++;
  end

  // {op_run,cart,speed,pos,wrer,retr,spin,usel} , wait , {run,rdy,lh,purge,em,brake,lock,safe}
  localparam logic [23:0] STEPS [11] = '{
    {8'b00000100, 8'd4,  8'b00000001},
    {8'b10000100, 8'd6,  8'b00000001},
    {8'b11000100, 8'd3,  8'b10000010},
    {8'b11100110, 8'd4,  8'b10010010},
    {8'b11100010, 8'd10, 8'b10100010},
    {8'b11110010, 8'd2,  8'b11100010},
    {8'b11110011, 8'd10, 8'b11100010},
    {8'b01111011, 8'd4,  8'b00100010},
    {8'b01110011, 8'd3,  8'b00000010},
    {8'b01110111, 8'd3,  8'b00000110},
    {8'b01000100, 8'd14, 8'b00000001}
  };

  function automatic string tag_of(int i);
    case (i)
      1: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      7, 8: return "R8"; 9: return "R9"; 10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic recover();
    op_run = 0; host_run = 0; flt = '0; disk_speed_err = 0; speed_ok = 0; pos_mode = 0;
    wr_er_active = 0; heads_retracted = 1; spin = 0;
    wait_clk(30);
    chk(safe_lamp && !emerg_flag, "R6 flag clears at rest", {safe_lamp, emerg_flag}, 2'b10);
  endtask

  task automatic bring_up(input bit via_host);
    cart_in = 1; heads_retracted = 1;
    if (via_host) host_run = 1; else op_run = 1;
    wait_clk(3);
    speed_ok = 1; spin = 1; pos_mode = 1;
    wait_clk(16);
    heads_retracted = 0;
  endtask

  initial begin
    logic [7:0] obs;
    #(CLK_PERIOD * 3) rst_n = 1'b1;
    wait_clk(1);
    chk({start_pulse, emerg_flag, relay_en, brake_en, load_or_purge_n, safe_lamp} == 6'b000011,
        "R11 reset state", {start_pulse, emerg_flag, relay_en, brake_en, load_or_purge_n, safe_lamp}, 6'b000011);

    for (int i = 0; i < 11; i++) begin
      {op_run, cart_in, speed_ok, pos_mode, wr_er_active, heads_retracted, spin, unit_sel} = STEPS[i][23:16];
      wait_clk(int'(STEPS[i][15:8]));
      obs = {run_lamp, ready_o, load_heads, purge_o, emerg_flag, brake_en, cart_lock, safe_lamp};
      chk(obs == STEPS[i][7:0], $sformatf("%s step %0d", tag_of(i), i), obs, STEPS[i][7:0]);
    end
    chk(pcnt == 1, "R1 one pulse from operator start", pcnt, 1);

    // R1 host start, R4 decode, R12 delayed and selected ready
    pcnt = 0; unit_sel = 0; cart_in = 1; heads_retracted = 1; host_run = 1;
    wait_clk(3);
    speed_ok = 1; spin = 1; pos_mode = 1;
    for (int k = 0; k < 60 && !ready_o; k++) wait_clk(1);
    chk(ready_o && !dly_ready, "R12 delayed ready low on entry", {ready_o, dly_ready}, 2'b10);
    chk(pcnt == 1, "R1 one pulse from host start", pcnt, 1);
    chk(!load_or_purge_n && ready_lamp, "R4 decode low with heads loaded", {load_or_purge_n, ready_lamp}, 2'b01);
    chk(!sel_ready, "R12 not selected", sel_ready, 0);
    wait_clk(8);
    chk(dly_ready, "R12 delayed ready after delay", dly_ready, 1);
    unit_sel = 1; #1;
    chk(sel_ready, "R12 selected and ready", sel_ready, 1);
    recover();

    // R3 spin-up timeout
    cart_in = 1; op_run = 1; heads_retracted = 0;
    wait_clk(24);
    chk(emerg_flag && relay_en && !run_lamp, "R3 spin-up timeout", {emerg_flag, relay_en, run_lamp}, 3'b110);
    recover();

    // R5 head-load timeout
    cart_in = 1; op_run = 1; heads_retracted = 0; speed_ok = 1; spin = 1;
    wait_clk(35);
    chk(emerg_flag && relay_en && !load_heads, "R5 load timeout", {emerg_flag, relay_en, load_heads}, 3'b110);
    recover();

    // R7 disk speed error before and after ready
    cart_in = 1; op_run = 1; heads_retracted = 0; speed_ok = 1; spin = 1; disk_speed_err = 1;
    wait_clk(5);
    chk(purge_o && !emerg_flag, "R7 ignored before ready", {purge_o, emerg_flag}, 2'b10);
    pos_mode = 1;
    wait_clk(20);
    chk(emerg_flag && relay_en, "R7 acts once ready", {emerg_flag, relay_en}, 2'b11);
    recover();

    // R6 each fault source from ready
    for (int f = 0; f < 6; f++) begin
      bring_up(f[0]);
      chk(ready_o, "R6 ready before fault", ready_o, 1);
      flt[f] = 1'b1;
      wait_clk(2);
      chk(emerg_flag && relay_en && !load_heads, $sformatf("R6 fault source %0d", f),
          {emerg_flag, relay_en, load_heads}, 3'b110);
      recover();
    end

    // R10 lock while rotating at rest
    spin = 1;
    wait_clk(4);
    chk(cart_lock && !safe_lamp, "R10 lock at rest while rotating", {cart_lock, safe_lamp}, 2'b10);
    spin = 0;
    wait_clk(14);
    chk(!cart_lock && safe_lamp, "R10 unlock after rotation stops", {cart_lock, safe_lamp}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule